// File: doc/BRIEF.md
# Flash Save Emulation Engine

This engine makes a plain word-addressed backing memory behave like a flash save device. It watches a status word that a bus-side decoder maintains. While the pending bit of that word is clear, the engine does nothing. When the bit is set, the engine decodes the request and runs one of three operations. A whole-chip erase and a sector erase fill a region with all-ones words. A page program merges a 32-word page buffer into memory with a bitwise AND, so that bits can only be cleared. When the operation is complete, the engine writes a done code back into the status word, and that write clears the pending state.

The save area starts at a word address supplied by the configuration logic. Sector erase and page program both locate their region from an index field in the upper bits of the status word: the region starts at save base plus the page size in words times that index. Addresses wrap modulo the memory address width.

The memory side is a single request port. A write completes on a cycle where `mem_ready` is high. A read is accepted the same way, and its data returns later with `mem_rvalid`. A `busy` output covers the whole operation.

Top module: `flash_save_engine`

## Requirements
- R1: After reset, `busy`, `mem_we`, `mem_re` and `stat_we` are all low.
- R2: While status bit 0 (pending) is clear, no memory request is issued and memory is left unchanged, whatever the other status bits hold.
- R3: With pending set, bit 1 (erase) set and bit 2 (whole) set, exactly CHIP_WORDS consecutive words starting at `save_base` become 0xFFFFFFFF, and no other word changes.
- R4: With pending set, erase set and whole clear, exactly SECTOR_WORDS words starting at `save_base + PAGE_WORDS*index` become 0xFFFFFFFF, and no other word changes. The index is status bits [STAT_W-1:IDX_LSB].
- R5: With pending set and erase clear, each of the PAGE_WORDS words at `save_base + PAGE_WORDS*index + k` becomes its old value AND page buffer word k, and no other word changes. Page buffer word k is `page_buf[k*DATA_W +: DATA_W]`.
- R6: During a program, at most one read is outstanding. Each word is written only after its read data has returned, and it is written to the address that was read.
- R7: While `mem_ready` is low, a pending request keeps its address, data and type unchanged.
- R8: The done code, a status word with only bit 3 set, is written with `stat_we` exactly once per operation. That write happens in the cycle after the final memory write is accepted.
- R9: `busy` is high from the cycle after pending is first seen until the done write. It is low in the cycle after the done write.
- R10: During a program, the whole bit (bit 2) has no effect: the operation still touches only its page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_q | input | STAT_W | Current status word |
| save_base | input | ADDR_W | Word address where the save area starts |
| page_buf | input | PAGE_WORDS*DATA_W | Page buffer; word k is at bits k*DATA_W |
| stat_we | output | 1 | Write strobe for the status word |
| stat_wd | output | STAT_W | Status value written (done code) |
| busy | output | 1 | Operation in progress |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid |
| mem_ready | input | 1 | Memory accepts the current request |

## Verification
`busy` rises at the first clock edge that sees pending, so the bench sets pending after a falling edge and checks `busy` at the next falling edge. The done write is due one cycle after the last accepted memory write, and `busy` drops one cycle after that. The bench timestamps both events in its memory model and compares the cycle difference. The contents of memory are checked only after the status word shows pending cleared, and the comparison covers the whole image against an array that the bench updates arithmetically. Ordering and stall stability are monitored on every edge by counters in the memory model.

// File: rtl/fse_pkg.sv
package fse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_POST
  } fse_state_t;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_SECT,
    OP_CHIP
  } fse_op_t;

  // erase bit chooses erase; whole bit only matters when erasing
  function automatic fse_op_t decode_op(input logic erase, input logic whole);
    if (!erase) return OP_PROG;
    return whole ? OP_CHIP : OP_SECT;
  endfunction

  // first word of the region an operation works on
  function automatic logic [31:0] region_start(input fse_op_t op,
                                               input logic [31:0] base,
                                               input logic [31:0] idx,
                                               input logic [31:0] page_words);
    if (op == OP_CHIP) return base;
    return base + idx * page_words;
  endfunction

  // index of the final word of the region
  function automatic logic [31:0] region_last(input fse_op_t op,
                                              input logic [31:0] page_words,
                                              input logic [31:0] sector_words,
                                              input logic [31:0] chip_words);
    case (op)
      OP_CHIP: return chip_words - 1;
      OP_SECT: return sector_words - 1;
      default: return page_words - 1;
    endcase
  endfunction

  function automatic logic [31:0] merge_word(input logic [31:0] old_w,
                                             input logic [31:0] buf_w);
    return old_w & buf_w;
  endfunction

endpackage

// File: rtl/fse_decode.sv
module fse_decode
  import fse_pkg::*;
#(
  parameter int STAT_W       = 32,
  parameter int ADDR_W       = 24,
  parameter int CNT_W        = 15,
  parameter int PEND_BIT     = 0,
  parameter int ERASE_BIT    = 1,
  parameter int WHOLE_BIT    = 2,
  parameter int IDX_LSB      = 16,
  parameter int PAGE_WORDS   = 32,
  parameter int SECTOR_WORDS = 4096,
  parameter int CHIP_WORDS   = 32768
) (
  input  logic [STAT_W-1:0] stat_q,
  input  logic [ADDR_W-1:0] save_base,
  output logic              pend_o,
  output fse_op_t           op_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [CNT_W-1:0]  last_o
);
  localparam int IDX_W = STAT_W - IDX_LSB;

  logic [IDX_W-1:0] idx;
  logic [31:0]      start_full;
  logic [31:0]      last_full;
  logic             stat_unused;

  assign stat_unused = ^stat_q[IDX_LSB-1:0];
  assign pend_o      = stat_q[PEND_BIT];
  assign idx         = stat_q[STAT_W-1:IDX_LSB];
  assign op_o        = decode_op(stat_q[ERASE_BIT], stat_q[WHOLE_BIT]);

  assign start_full = region_start(op_o, 32'(save_base), 32'(idx), 32'(PAGE_WORDS));
  assign last_full  = region_last(op_o, 32'(PAGE_WORDS), 32'(SECTOR_WORDS), 32'(CHIP_WORDS));

  assign start_o = start_full[ADDR_W-1:0];
  assign last_o  = last_full[CNT_W-1:0];
endmodule

// File: rtl/fse_walker.sv
module fse_walker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_in,
  input  logic [CNT_W-1:0]  last_in,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      last_q  <= '0;
      cnt     <= '0;
    end else if (load) begin
      start_q <= start_in;
      last_q  <= last_in;
      cnt     <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  generate
    if (CNT_W >= ADDR_W) begin : g_wide_cnt
      assign addr = start_q + cnt[ADDR_W-1:0];
    end else begin : g_narrow_cnt
      assign addr = start_q + {{(ADDR_W-CNT_W){1'b0}}, cnt};
    end
  endgenerate

  assign at_last = (cnt == last_q);
endmodule

// File: rtl/fse_ctrl.sv
module fse_ctrl
  import fse_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend,
  input  fse_op_t    op_in,
  input  logic       at_last,
  input  logic       mem_ready,
  input  logic       mem_rvalid,
  output fse_state_t state,
  output fse_op_t    op_q,
  output logic       accept,
  output logic       step,
  output logic       capture,
  output logic       wr_accept,
  output logic       rd_accept
);
  fse_state_t state_d;

  assign accept    = (state == ST_IDLE) && pend;
  assign wr_accept = ((state == ST_ERASE) || (state == ST_WR)) && mem_ready;
  assign rd_accept = (state == ST_RD) && mem_ready;
  assign capture   = (state == ST_WAIT) && mem_rvalid;
  assign step      = wr_accept && !at_last;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (pend) state_d = (op_in == OP_PROG) ? ST_RD : ST_ERASE;
      ST_ERASE: if (mem_ready && at_last) state_d = ST_POST;
      ST_RD:    if (mem_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rvalid) state_d = ST_WR;
      ST_WR:    if (mem_ready) state_d = at_last ? ST_POST : ST_RD;
      ST_POST:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_PROG;
    end else begin
      state <= state_d;
      if (accept) op_q <= op_in;
    end
  end
endmodule

// File: rtl/flash_save_engine.sv
module flash_save_engine
  import fse_pkg::*;
#(
  parameter int STAT_W       = 32,
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 32,
  parameter int PAGE_WORDS   = 32,
  parameter int SECTOR_WORDS = 4096,
  parameter int CHIP_WORDS   = 32768,
  parameter int PEND_BIT     = 0,
  parameter int ERASE_BIT    = 1,
  parameter int WHOLE_BIT    = 2,
  parameter int DONE_BIT     = 3,
  parameter int IDX_LSB      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [STAT_W-1:0]            stat_q,
  input  logic [ADDR_W-1:0]            save_base,
  input  logic [PAGE_WORDS*DATA_W-1:0] page_buf,
  output logic                         stat_we,
  output logic [STAT_W-1:0]            stat_wd,
  output logic                         busy,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         mem_we,
  output logic                         mem_re,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  input  logic                         mem_rvalid,
  input  logic                         mem_ready
);
  localparam int MAX_WORDS = (CHIP_WORDS > SECTOR_WORDS) ?
                             ((CHIP_WORDS > PAGE_WORDS) ? CHIP_WORDS : PAGE_WORDS) :
                             ((SECTOR_WORDS > PAGE_WORDS) ? SECTOR_WORDS : PAGE_WORDS);
  localparam int CNT_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int PG_W  = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam logic [STAT_W-1:0] DONE_CODE = STAT_W'(1) << DONE_BIT;

  // named internal events
  logic              dec_pend;
  fse_op_t           dec_op;
  logic [ADDR_W-1:0] dec_start;
  logic [CNT_W-1:0]  dec_last;
  fse_state_t        state;
  fse_op_t           op_q;
  logic              accept;
  logic              step;
  logic              capture;
  logic              wr_accept;
  logic              rd_accept;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] walk_addr;
  logic              at_last;
  logic              erase_active;
  logic              done_post;
  logic [DATA_W-1:0] page_word;
  logic [DATA_W-1:0] merged_q;
  logic [PG_W-1:0]   page_sel;

  fse_decode #(
    .STAT_W(STAT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .PEND_BIT(PEND_BIT), .ERASE_BIT(ERASE_BIT), .WHOLE_BIT(WHOLE_BIT),
    .IDX_LSB(IDX_LSB), .PAGE_WORDS(PAGE_WORDS),
    .SECTOR_WORDS(SECTOR_WORDS), .CHIP_WORDS(CHIP_WORDS)
  ) u_decode (
    .stat_q   (stat_q),
    .save_base(save_base),
    .pend_o   (dec_pend),
    .op_o     (dec_op),
    .start_o  (dec_start),
    .last_o   (dec_last)
  );

  fse_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (dec_pend),
    .op_in     (dec_op),
    .at_last   (at_last),
    .mem_ready (mem_ready),
    .mem_rvalid(mem_rvalid),
    .state     (state),
    .op_q      (op_q),
    .accept    (accept),
    .step      (step),
    .capture   (capture),
    .wr_accept (wr_accept),
    .rd_accept (rd_accept)
  );

  fse_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (step),
    .start_in(dec_start),
    .last_in (dec_last),
    .cnt     (cnt),
    .addr    (walk_addr),
    .at_last (at_last)
  );

  assign page_sel  = cnt[PG_W-1:0];
  assign page_word = page_buf[page_sel*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) merged_q <= '0;
    else if (capture) merged_q <= DATA_W'(merge_word(32'(mem_rdata), 32'(page_word)));
  end

  assign erase_active = (op_q != OP_PROG);
  assign done_post    = (state == ST_POST);

  assign busy      = (state != ST_IDLE);
  assign mem_we    = (state == ST_ERASE) || (state == ST_WR);
  assign mem_re    = (state == ST_RD);
  assign mem_addr  = walk_addr;
  assign mem_wdata = erase_active ? {DATA_W{1'b1}} : merged_q;
  assign stat_we   = done_post;
  assign stat_wd   = DONE_CODE;
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 32,
  parameter int DONE_BIT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic              mem_ready,
  input logic              mem_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              stat_we,
  input logic [STAT_W-1:0] stat_wd,
  input logic              erase_active,
  input logic              rd_accept
);
  logic              rd_open;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_open   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (rd_accept) begin
        rd_open   <= 1'b1;
        rd_addr_q <= mem_addr;
      end else if (mem_rvalid) begin
        rd_open <= 1'b0;
      end
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));

  assert_erase_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && erase_active) |-> (&mem_wdata));

  assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !(mem_we || mem_re));

  assert_write_read_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !erase_active) |-> (mem_addr == rd_addr_q));

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_we) && $stable(mem_re) && $stable(mem_wdata)));

  assert_done_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (stat_wd == (STAT_W'(1) << DONE_BIT)) && busy && !mem_we && !mem_re);

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> !busy);
endmodule

bind flash_save_engine fse_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .DONE_BIT(DONE_BIT)
) u_fse_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .mem_we      (mem_we),
  .mem_re      (mem_re),
  .mem_ready   (mem_ready),
  .mem_rvalid  (mem_rvalid),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .stat_we     (stat_we),
  .stat_wd     (stat_wd),
  .erase_active(erase_active),
  .rd_accept   (rd_accept)
);

// File: tb/test_flash_save_engine.sv
`timescale 1ns/1ps
module test_flash_save_engine;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int SW = 32;
  localparam int PW = 32;
  localparam int SECW = 128;
  localparam int CHW = 512;
  localparam int MEMN = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] stat_reg = '0;
  logic [AW-1:0] save_base = '0;
  logic [PW*DW-1:0] page_buf = '0;
  logic          stat_we;
  logic [SW-1:0] stat_wd;
  logic          busy;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_rvalid;
  logic          mem_ready;

  logic [DW-1:0] mem [MEMN];
  logic [DW-1:0] exp_mem [MEMN];

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  logic [15:0] lfsr = 16'hACE1;
  logic        stall_en = 1'b0;
  logic        rv1 = 1'b0, rv2 = 1'b0;
  logic [DW-1:0] rd1 = '0, rd2 = '0;
  logic        rd_open = 1'b0;
  logic [AW-1:0] last_rd_addr = '0;
  logic        cur_prog = 1'b0;
  int          cyc = 0;
  int          last_wr_cyc = 0;
  int          done_cyc = 0;
  int          n_req = 0;
  int          n_done = 0;
  int          order_err = 0;
  int          hold_err = 0;
  logic        prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_wdata = '0;
  logic        prev_we = 1'b0, prev_re = 1'b0;

  always #4 clk = ~clk;

  flash_save_engine #(
    .STAT_W(SW), .ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PW),
    .SECTOR_WORDS(SECW), .CHIP_WORDS(CHW), .IDX_LSB(16)
  ) i_flash_save_engine (
    .clk(clk), .rst_n(rst_n), .stat_q(stat_reg), .save_base(save_base),
    .page_buf(page_buf), .stat_we(stat_we), .stat_wd(stat_wd), .busy(busy),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_ready(mem_ready)
  );

  assign mem_ready  = !stall_en || (lfsr[1:0] != 2'b00);
  assign mem_rvalid = rv2;
  assign mem_rdata  = rd2;

  // memory and status model
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rv2 <= rv1; rd2 <= rd1; rv1 <= 1'b0;
    if (rv2) rd_open <= 1'b0;
    if ((mem_we || mem_re) && mem_ready) n_req <= n_req + 1;
    if (mem_re && mem_ready) begin
      rv1 <= 1'b1; rd1 <= mem[mem_addr]; rd_open <= 1'b1; last_rd_addr <= mem_addr;
    end
    if (mem_we && mem_ready) begin
      mem[mem_addr] <= mem_wdata;
      last_wr_cyc <= cyc;
      if (cur_prog && (rd_open || mem_addr != last_rd_addr)) order_err <= order_err + 1;
    end
    if (prev_stall && (mem_addr != prev_addr || mem_we != prev_we ||
                       mem_re != prev_re || mem_wdata != prev_wdata))
      hold_err <= hold_err + 1;
    prev_stall <= (mem_we || mem_re) && !mem_ready;
    prev_addr <= mem_addr; prev_we <= mem_we; prev_re <= mem_re; prev_wdata <= mem_wdata;
    if (stat_we) begin
      stat_reg <= stat_wd;
      done_cyc <= cyc;
      n_done <= n_done + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] seed_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] buf_word(input int k, input int seed);
    return ((k + 1) * 32'h0101_0101 * (seed + 3)) ^ (32'hF0F0_F0F0 >> (k % 8));
  endfunction

  task automatic cmp_image(input string req);
    int diffs = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) diffs++;
    chk(req, diffs, 0);
  endtask

  // erase: 1 = erase, whole: 1 = chip; idx into upper status bits
  task automatic run_op(input string req, input bit erase, input bit whole,
                        input int idx, input int base, input int seed, input bit stall);
    int start, len, guard, d0;
    @(negedge clk);
    stall_en  = stall;
    save_base = AW'(base);
    for (int k = 0; k < PW; k++) page_buf[k*DW +: DW] = buf_word(k, seed);
    cur_prog = !erase;
    if (erase && whole) begin start = base; len = CHW; end
    else begin start = base + PW * idx; len = erase ? SECW : PW; end
    for (int j = 0; j < len; j++) begin
      int a = (start + j) % MEMN;
      exp_mem[a] = erase ? 32'hFFFF_FFFF : (exp_mem[a] & buf_word(j, seed));
    end
    d0 = n_done;
    stat_reg = (SW'(idx) << 16) | (SW'(whole) << 2) | (SW'(erase) << 1) | 32'h1;
    @(negedge clk);
    chk({req, " R9 busy after pending"}, busy, 1);
    guard = 0;
    while (stat_reg[0] && guard < 8000) begin @(negedge clk); guard++; end
    chk({req, " R9 busy low after done"}, busy, 0);
    chk({req, " R8 done code"}, stat_reg, 32'h8);
    chk({req, " R8 one done write"}, n_done - d0, 1);
    chk({req, " R8 done latency"}, done_cyc - last_wr_cyc, 1);
    cmp_image(req);
    chk({req, " R6 order"}, order_err, 0);
    chk({req, " R7 hold"}, hold_err, 0);
  endtask

  initial begin
    int r0;
    for (int i = 0; i < MEMN; i++) begin mem[i] = seed_word(i); exp_mem[i] = seed_word(i); end
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_re", mem_re, 0);
    chk("R1 stat_we", stat_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", busy, 0);

    // R2: every non-pending status combination stays quiet
    r0 = n_req;
    for (int v = 0; v < 8; v++) begin
      stat_reg = (SW'(v) << 1) | (SW'(v + 2) << 16);
      repeat (4) @(negedge clk);
    end
    chk("R2 no requests", n_req - r0, 0);
    chk("R2 busy", busy, 0);
    cmp_image("R2 image");

    // R5 page program sweep over bases and indices
    for (int b = 0; b < 2; b++)
      for (int x = 0; x < 4; x++)
        run_op("R5 program", 1'b0, 1'b0, (x == 3) ? 63 : x * 5, b * 777, b * 4 + x, x[0]);

    // R4 sector erase
    run_op("R4 sector", 1'b1, 1'b0, 0, 100, 0, 1'b0);
    run_op("R4 sector", 1'b1, 1'b0, 3, 100, 0, 1'b1);
    run_op("R4 sector", 1'b1, 1'b0, 50, 100, 0, 1'b1);
    // program into erased area: result equals buffer
    run_op("R5 program erased", 1'b0, 1'b0, 4, 100, 9, 1'b1);

    // R3 whole erase at two bases, one reaching the top of memory
    run_op("R3 chip", 1'b1, 1'b1, 7, 3584, 0, 1'b1);
    run_op("R3 chip", 1'b1, 1'b1, 0, 200, 0, 1'b0);

    // R10 whole bit set on a program
    run_op("R10 program whole bit", 1'b0, 1'b1, 20, 1500, 11, 1'b1);
    run_op("R10 program whole bit", 1'b0, 1'b1, 2, 40, 12, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule